// File: doc/BRIEF.md
# Stride Prediction Table Prefetcher

This block observes executed memory operations, each presented as the address of the load or store instruction and the data address it touched. A sixteen-entry, fully associative table keyed by instruction address keeps the most recent data address seen for each memory instruction. When an instruction that is already tracked executes again, the block takes the difference between its new data address and the stored one as a stride. It then requests a prefetch of the line that lies one stride beyond the current access.

A small control state machine paces the work. In state IDLE the operation input is ready. An accepted operation is captured, and the machine moves IDLE -> LOOKUP. In LOOKUP the table is searched, updated and replacement-ordered. Any prefetch request is loaded into the output register, and the machine returns LOOKUP -> IDLE unconditionally. IDLE stays in IDLE while no operation is offered. The output holds one request at a time; a newer request overwrites one that has not yet been taken.

Top module: `spt_prefetcher`

## Requirements
- R1: After reset every table entry is invalid, `pf_valid` is 0 and `op_ready` is 1, so the first operation of any instruction address is a table miss.
- R2: An operation is accepted on a rising edge where `op_valid` and `op_ready` are both 1; `op_ready` is 0 for exactly the next cycle (state LOOKUP) and returns to 1 after it.
- R3: On a table miss no prefetch request is produced, and an entry is allocated with the instruction address and the current data address.
- R4: On a hit the stride is the current data address minus the stored one; when it is non-zero, `pf_valid` is 1 and `pf_addr` equals the current data address plus the stride, aligned down, from the second rising edge after acceptance.
- R5: On a hit with a stride of zero no prefetch request is produced.
- R6: The stride is a signed two's-complement value modulo 2^DADDR_W, so a descending pattern produces a prefetch below the current address.
- R7: On a hit the stored data address is replaced by the current one, so the next stride is measured from the most recent access.
- R8: When all entries are valid, a miss replaces the least recently used entry, where both allocation and hits make an entry most recently used; invalid entries are filled first.
- R9: `pf_addr` is aligned down to a 16-byte line: its low 4 bits are always 0.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, the request is held unchanged until a newer request replaces it; a handshake with no new request clears `pf_valid`.
- R11: Entries for different instruction addresses are independent; a stride is computed only from the history of the same instruction address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Memory operation offered |
| op_ready | output | 1 | Block can accept an operation (state IDLE) |
| op_iaddr | input | IADDR_W (32) | Instruction address of the operation |
| op_daddr | input | DADDR_W (32) | Data address of the operation |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer takes the pending request |
| pf_addr | output | DADDR_W (32) | Line-aligned prefetch address |

## Verification
The assertions assume that `op_iaddr` and `op_daddr` are stable while `op_valid` is high and the machine is in IDLE. They also assume that reset is held low for at least one rising edge before any operation is offered. The directed tasks raise `op_valid` only in IDLE and drop it right after the accepting edge. They change `pf_ready` only between operations. They start the eviction test from a fresh reset, so the replacement order is fully known.

// File: rtl/spt_pkg.sv
package spt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_LOOKUP = 1'b1
    } spt_state_e;
endpackage

// File: rtl/spt_lru.sv
module spt_lru #(
    parameter int ENTRIES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       touch_en,
    input  logic [$clog2(ENTRIES)-1:0] touch_idx,
    output logic [$clog2(ENTRIES)-1:0] lru_idx
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0] age [ENTRIES];
    logic [ENTRIES-1:0] is_old;

    // Ages form a permutation; 0 is most recent, ENTRIES-1 is least recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (IDX_W'(i) == touch_idx)
                    age[i] <= '0;
                else if (age[i] < age[touch_idx])
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_old
        assign is_old[g] = (age[g] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        lru_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (is_old[i]) lru_idx = IDX_W'(i);
    end

    // R8
    single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1);
endmodule

// File: rtl/spt_table.sv
module spt_table #(
    parameter int ENTRIES = 16,
    parameter int IADDR_W = 32,
    parameter int DADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lookup_en,
    input  logic [IADDR_W-1:0] key_iaddr,
    input  logic [DADDR_W-1:0] cur_daddr,
    output logic               hit,
    output logic [DADDR_W-1:0] prev_daddr
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic               ent_valid [ENTRIES];
    logic [IADDR_W-1:0] ent_tag   [ENTRIES];
    logic [DADDR_W-1:0] ent_last  [ENTRIES];

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               has_free;
    logic [IDX_W-1:0]   lru_idx;
    logic [IDX_W-1:0]   wr_idx;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_tag[g] == key_iaddr);
    end

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        has_free = 1'b0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) hit_idx = hit_idx | IDX_W'(i);
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    assign hit        = |match;
    assign prev_daddr = ent_last[hit_idx];
    assign wr_idx     = hit ? hit_idx : (has_free ? free_idx : lru_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_valid[i] <= 1'b0;
                ent_tag[i]   <= '0;
                ent_last[i]  <= '0;
            end
        end else if (lookup_en) begin
            ent_valid[wr_idx] <= 1'b1;
            ent_tag[wr_idx]   <= key_iaddr;
            ent_last[wr_idx]  <= cur_daddr;
        end
    end

    spt_lru #(.ENTRIES(ENTRIES)) i_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (lookup_en),
        .touch_idx (wr_idx),
        .lru_idx   (lru_idx)
    );

    // R11
    unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/spt_req_out.sv
module spt_req_out #(
    parameter int DADDR_W    = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DADDR_W-1:0] load_addr,
    input  logic               pf_ready,
    output logic               pf_valid,
    output logic [DADDR_W-1:0] pf_addr
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [DADDR_W-1:0] LINE_MASK = ~DADDR_W'(LINE_BYTES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else if (load) begin
            pf_valid <= 1'b1;
            pf_addr  <= load_addr & LINE_MASK;
        end else if (pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    // R10
    pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !load) |=> (pf_valid && $stable(pf_addr)));

    // R9
    line_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFF_W-1:0] == '0));
endmodule

// File: rtl/spt_prefetcher.sv
module spt_prefetcher
    import spt_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int IADDR_W    = 32,
    parameter int DADDR_W    = 32,
    parameter int LINE_BYTES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    output logic               op_ready,
    input  logic [IADDR_W-1:0] op_iaddr,
    input  logic [DADDR_W-1:0] op_daddr,
    output logic               pf_valid,
    input  logic               pf_ready,
    output logic [DADDR_W-1:0] pf_addr
);
    spt_state_e state_q, state_d;

    logic               accept;
    logic               do_lookup;
    logic [IADDR_W-1:0] cap_iaddr;
    logic [DADDR_W-1:0] cap_daddr;
    logic               tbl_hit;
    logic [DADDR_W-1:0] tbl_prev;
    logic [DADDR_W-1:0] stride;
    logic [DADDR_W-1:0] next_addr;
    logic               issue;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        op_ready  = 1'b0;
        do_lookup = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                op_ready = 1'b1;
                if (op_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                do_lookup = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign accept = op_valid && op_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_iaddr <= '0;
            cap_daddr <= '0;
        end else if (accept) begin
            cap_iaddr <= op_iaddr;
            cap_daddr <= op_daddr;
        end
    end

    spt_table #(
        .ENTRIES (ENTRIES),
        .IADDR_W (IADDR_W),
        .DADDR_W (DADDR_W)
    ) i_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_en  (do_lookup),
        .key_iaddr  (cap_iaddr),
        .cur_daddr  (cap_daddr),
        .hit        (tbl_hit),
        .prev_daddr (tbl_prev)
    );

    // Two's-complement wrap gives signed strides for free.
    assign stride    = cap_daddr - tbl_prev;
    assign next_addr = cap_daddr + stride;
    assign issue     = do_lookup && tbl_hit && (stride != '0);

    spt_req_out #(
        .DADDR_W    (DADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) i_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (issue),
        .load_addr (next_addr),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_addr   (pf_addr)
    );

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !op_ready);

    // R2
    ready_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_ready |=> op_ready);

    // R3
    miss_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_lookup && !tbl_hit) |=> (!pf_valid || $stable(pf_addr)));
endmodule

// File: tb/test_spt_prefetcher.sv
module test_spt_prefetcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic [31:0] op_iaddr = '0;
    logic [31:0] op_daddr = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    spt_prefetcher i_spt_prefetcher (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_ready (op_ready),
        .op_iaddr (op_iaddr),
        .op_daddr (op_daddr),
        .pf_valid (pf_valid),
        .pf_ready (pf_ready),
        .pf_addr  (pf_addr)
    );

    function automatic logic [31:0] predict(logic [31:0] cur, logic [31:0] last);
        logic [31:0] s;
        s = cur - last;
        return (cur + s) & 32'hFFFF_FFF0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_pf(string req, logic exp_v, logic [31:0] exp_a);
        chk(req, {31'd0, pf_valid}, {31'd0, exp_v});
        if (exp_v) chk(req, pf_addr, exp_a);
    endtask

    // Issues one operation from IDLE and returns at the falling edge after
    // the lookup edge, where the request register shows the result.
    task automatic op(logic [31:0] ia, logic [31:0] da);
        @(negedge clk);
        op_iaddr = ia;
        op_daddr = da;
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check_pf("R1", 1'b0, 32'h0);
        chk("R1", {31'd0, op_ready}, 32'd1);
        op(32'h0000_0100, 32'h0000_1000);
        check_pf("R1", 1'b0, 32'h0);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        op_iaddr = 32'h0000_0200;
        op_daddr = 32'h0000_0800;
        op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R2", {31'd0, op_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R2", {31'd0, op_ready}, 32'd1);
        check_pf("R3", 1'b0, 32'h0);
    endtask

    task automatic t_ascend();
        op(32'h0000_0100, 32'h0000_1040);
        check_pf("R4", 1'b1, predict(32'h1040, 32'h1000));
        op(32'h0000_0100, 32'h0000_1080);
        check_pf("R4", 1'b1, 32'h0000_10C0);
    endtask

    task automatic t_zero();
        op(32'h0000_0104, 32'h0000_2000);
        check_pf("R3", 1'b0, 32'h0);
        op(32'h0000_0104, 32'h0000_2000);
        check_pf("R5", 1'b0, 32'h0);
    endtask

    task automatic t_descend();
        op(32'h0000_0108, 32'h0000_3000);
        op(32'h0000_0108, 32'h0000_2FE0);
        check_pf("R6", 1'b1, 32'h0000_2FC0);
    endtask

    task automatic t_update();
        op(32'h0000_010C, 32'h0000_4000);
        op(32'h0000_010C, 32'h0000_4010);
        check_pf("R7", 1'b1, 32'h0000_4020);
        op(32'h0000_010C, 32'h0000_4030);
        check_pf("R7", 1'b1, predict(32'h4030, 32'h4010));
    endtask

    task automatic t_align();
        op(32'h0000_0110, 32'h0000_5003);
        op(32'h0000_0110, 32'h0000_5008);
        check_pf("R9", 1'b1, 32'h0000_5000);
        chk("R9", {28'd0, pf_addr[3:0]}, 32'd0);
    endtask

    task automatic t_indep();
        op(32'h0000_0120, 32'h0000_6000);
        op(32'h0000_0124, 32'h0000_7000);
        op(32'h0000_0120, 32'h0000_6100);
        check_pf("R11", 1'b1, 32'h0000_6200);
    endtask

    task automatic t_stall();
        pf_ready = 1'b0;
        op(32'h0000_0100, 32'h0000_10C0);
        check_pf("R10", 1'b1, 32'h0000_1100);
        repeat (3) @(negedge clk);
        check_pf("R10", 1'b1, 32'h0000_1100);
        op(32'h0000_0100, 32'h0000_1100);
        check_pf("R10", 1'b1, 32'h0000_1140);
        op(32'h0000_0104, 32'h0000_2000);
        check_pf("R10", 1'b1, 32'h0000_1140);
        pf_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_pf("R10", 1'b0, 32'h0);
    endtask

    task automatic t_lru();
        do_reset();
        op(32'h0000_0100, 32'h0000_1000);
        check_pf("R1", 1'b0, 32'h0);
        do_reset();
        for (int k = 0; k < 16; k++) begin
            op(32'h0000_0800 + 32'(k * 4), 32'h0010_0000 * 32'(k + 1));
            check_pf("R8", 1'b0, 32'h0);
        end
        op(32'h0000_0800, 32'h0010_0010);
        check_pf("R8", 1'b1, 32'h0010_0020);
        op(32'h0000_0900, 32'h0900_0000);
        check_pf("R8", 1'b0, 32'h0);
        op(32'h0000_0804, 32'h0020_0040);
        check_pf("R8", 1'b0, 32'h0);
        op(32'h0000_0800, 32'h0010_0020);
        check_pf("R8", 1'b1, 32'h0010_0030);
        op(32'h0000_080C, 32'h0040_0008);
        check_pf("R8", 1'b1, 32'h0040_0010);
        op(32'h0000_0808, 32'h0030_0040);
        check_pf("R8", 1'b0, 32'h0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_handshake();
        t_ascend();
        t_zero();
        t_descend();
        t_update();
        t_align();
        t_indep();
        t_stall();
        t_lru();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule